// File: doc/BRIEF.md
# Chunked Storage DMA Progress Tracker

This block keeps the running state of one storage DMA transfer while a descriptor-driven DMA engine moves it in chunks. A `start` pulse arms it. The remaining byte count is loaded from a sector count when the device is a hard disk, or from a packet transfer length when the device is an optical drive. The running index is cleared at the same time. Each chunk request names a host address and a length. For each one the block issues a device byte offset, lowers the remaining count and raises the index by the chunk length. It also gives the number of scatter-page entries the memory side should reserve for that chunk.

A chunk request that arrives when the remaining count is no longer positive ends the transfer. A chunk that arrives while nothing is armed is parked: it is reported and then ignored until the channel is started again. An optical transfer of non-block data copies at most what remains and ends on its first chunk. An error input aborts the transfer.

Top module: `dma_xfer_tracker`

## Requirements
- R1: One cycle after `start`, `active` is 1, `err_out` is 0 and `status_ready` is 0. The index is zero, so the first issued offset equals the base offset alone. A `start` while a transfer is active restarts it with the new inputs.
- R2: For a disk (`is_optical`=0), each issued offset is `blk_addr`×512 plus the running index. The remaining count starts at `sector_cnt`×512.
- R3: For an optical drive (`is_optical`=1, `nonblock`=0), each issued offset is `blk_addr`×2048 plus the running index. The remaining count starts at `pkt_len`.
- R4: Each issued chunk raises the running index by its length and lowers the remaining count by the same amount. The remaining count may go negative.
- R5: A chunk request while active with a remaining count of zero or less issues nothing. It pulses `done` and clears `active`. For a disk it also sets `status_ready` (ready plus seek complete); for an optical drive `status_ready` stays 0.
- R6: A chunk request while not active pulses `parked`. It issues nothing, and it changes neither the index nor the remaining count seen by the next transfer.
- R7: For an optical non-block transfer (`is_optical`=1, `nonblock`=1), the first chunk with a positive remaining count issues a length equal to the lesser of the remaining count and `chunk_len`. It pulses `done` in that same cycle and clears `active`.
- R8: `acct_done` pulses together with `done` only when the latched `cmd` is read (0) or write (1). It stays 0 for trim (2).
- R9: `err_in` while active clears `active` and sets `err_out` with no `done` pulse. `err_out` holds until the next `start`. `err_in` while idle has no effect.
- R10: `sg_pages` equals the issued length divided by 4096 (rounded down) plus 1.
- R11: `issue_valid`, `issue_*`, `parked`, `done` and `acct_done` appear exactly one clock after the chunk request is sampled. The pulses last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arm a new transfer |
| is_optical | input | 1 | 1 for an optical drive, 0 for a disk |
| nonblock | input | 1 | Optical non-block transfer |
| cmd | input | 2 | 0 read, 1 write, 2 trim |
| sector_cnt | input | CNT_W | Disk sector count |
| pkt_len | input | PKT_W | Optical packet transfer length in bytes |
| blk_addr | input | LBA_W | Disk sector number or optical block address |
| chunk_valid | input | 1 | Chunk request from the DMA engine |
| chunk_addr | input | ADDR_W | Host address of the chunk |
| chunk_len | input | LEN_W | Chunk length in bytes |
| err_in | input | 1 | Transfer error |
| active | output | 1 | Transfer armed |
| issue_valid | output | 1 | Chunk issued this cycle |
| issue_addr | output | ADDR_W | Host address of the issued chunk |
| issue_offset | output | OFS_W | Device byte offset of the issued chunk |
| issue_len | output | LEN_W | Issued length |
| sg_pages | output | PG_W | Scatter-page entries for the chunk |
| parked | output | 1 | Chunk request arrived while idle |
| done | output | 1 | Transfer finished |
| acct_done | output | 1 | Finished read or write, to be counted |
| status_ready | output | 1 | Device status ready plus seek complete |
| err_out | output | 1 | Transfer aborted by error |

## Verification
A wrong index or remaining count does not stay hidden. A bad index shows up in the offset of the very next issued chunk. A bad remaining count moves the cycle in which `done` appears to an earlier or later chunk request. A lost armed flag shows as a `parked` pulse where an issue was due, one clock after that request. The scoreboard compares every `issue_valid`, `done` and `parked` event in order against a model. It also checks the completion status and the accounting flags on each of those events.

// File: rtl/dma_xfer_tracker.sv
module dma_xfer_tracker #(
  parameter int CNT_W   = 16,
  parameter int PKT_W   = 24,
  parameter int LBA_W   = 32,
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int PAGE_LG = 12,
  localparam int SEC_BITS = CNT_W + 9,
  localparam int REM_W  = ((SEC_BITS > PKT_W) ? SEC_BITS : PKT_W) + 2,
  localparam int IDX_W  = REM_W,
  localparam int OFS_W  = (((LBA_W + 11) > IDX_W) ? (LBA_W + 11) : IDX_W) + 1,
  localparam int PG_W   = LEN_W - PAGE_LG + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_optical,
  input  logic              nonblock,
  input  logic [1:0]        cmd,
  input  logic [CNT_W-1:0]  sector_cnt,
  input  logic [PKT_W-1:0]  pkt_len,
  input  logic [LBA_W-1:0]  blk_addr,
  input  logic              chunk_valid,
  input  logic [ADDR_W-1:0] chunk_addr,
  input  logic [LEN_W-1:0]  chunk_len,
  input  logic              err_in,
  output logic              active,
  output logic              issue_valid,
  output logic [ADDR_W-1:0] issue_addr,
  output logic [OFS_W-1:0]  issue_offset,
  output logic [LEN_W-1:0]  issue_len,
  output logic [PG_W-1:0]   sg_pages,
  output logic              parked,
  output logic              done,
  output logic              acct_done,
  output logic              status_ready,
  output logic              err_out
);

  logic signed [REM_W-1:0] rem_q;
  logic [IDX_W-1:0]        idx_q;
  logic [LBA_W-1:0]        base_q;
  logic                    opt_q, nb_q;
  logic [1:0]              cmd_q;

  wire rem_pos   = !rem_q[REM_W-1] && (rem_q != '0);
  wire counted   = (cmd_q == 2'd0) || (cmd_q == 2'd1);
  wire one_shot  = opt_q && nb_q;

  wire [REM_W-1:0] len_ext  = REM_W'(chunk_len);
  wire [LEN_W-1:0] clip_len = (len_ext < $unsigned(rem_q)) ? chunk_len : rem_q[LEN_W-1:0];
  wire [LEN_W-1:0] use_len  = one_shot ? clip_len : chunk_len;

  wire [OFS_W-1:0] base_ext = OFS_W'(base_q);
  wire [OFS_W-1:0] base_off = opt_q ? (base_ext << 11) : (base_ext << 9);
  wire [OFS_W-1:0] next_off = base_off + OFS_W'(idx_q);

  wire signed [REM_W-1:0] load_rem = is_optical ? $signed(REM_W'(pkt_len))
                                                : $signed(REM_W'({sector_cnt, 9'b0}));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q        <= '0;
      idx_q        <= '0;
      base_q       <= '0;
      opt_q        <= 1'b0;
      nb_q         <= 1'b0;
      cmd_q        <= 2'd0;
      active       <= 1'b0;
      issue_valid  <= 1'b0;
      issue_addr   <= '0;
      issue_offset <= '0;
      issue_len    <= '0;
      sg_pages     <= '0;
      parked       <= 1'b0;
      done         <= 1'b0;
      acct_done    <= 1'b0;
      status_ready <= 1'b0;
      err_out      <= 1'b0;
    end else begin
      issue_valid <= 1'b0;
      parked      <= 1'b0;
      done        <= 1'b0;
      acct_done   <= 1'b0;
      if (start) begin
        rem_q        <= load_rem;
        idx_q        <= '0;
        base_q       <= blk_addr;
        opt_q        <= is_optical;
        nb_q         <= nonblock;
        cmd_q        <= cmd;
        active       <= 1'b1;
        status_ready <= 1'b0;
        err_out      <= 1'b0;
      end else if (active && err_in) begin
        active  <= 1'b0;
        err_out <= 1'b1;
      end else if (chunk_valid) begin
        if (!active) begin
          parked <= 1'b1;
        end else if (!rem_pos) begin
          done      <= 1'b1;
          acct_done <= counted;
          active    <= 1'b0;
          if (!opt_q) status_ready <= 1'b1;
        end else begin
          issue_valid  <= 1'b1;
          issue_addr   <= chunk_addr;
          issue_offset <= next_off;
          issue_len    <= use_len;
          sg_pages     <= PG_W'(use_len >> PAGE_LG) + PG_W'(1);
          rem_q        <= rem_q - $signed(REM_W'(use_len));
          idx_q        <= idx_q + IDX_W'(use_len);
          if (one_shot) begin
            done      <= 1'b1;
            acct_done <= counted;
            active    <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/dma_xfer_tracker_chk.sv
module dma_xfer_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic chunk_valid,
  input logic err_in,
  input logic active,
  input logic issue_valid,
  input logic parked,
  input logic done,
  input logic acct_done,
  input logic status_ready,
  input logic err_out
);

  a_r1_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && !err_out && !status_ready));

  a_r5_done_drops_active: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active);

  a_r6_idle_chunk_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && !active && !start) |=> (parked && !issue_valid && !done));

  a_r8_acct_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    acct_done |-> done);

  a_r9_error_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_out |-> (!active && !done));

  a_r9_error_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (active && err_in && !start) |=> (err_out && !active));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_parked_single: assert property (@(posedge clk) disable iff (!rst_n)
    parked |-> $countones({parked, issue_valid}) == 1);

endmodule

bind dma_xfer_tracker dma_xfer_tracker_chk u_chk (.*);

// File: tb/sim_dma_xfer_tracker.sv
module sim_dma_xfer_tracker;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          iss, dn, prk, acct, stat;
    longint      ofs;
    int          len, pgs;
    int unsigned addr;
    string       req;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic        start = 0, is_optical = 0, nonblock = 0, chunk_valid = 0, err_in = 0;
  logic [1:0]  cmd = 0;
  logic [15:0] sector_cnt = 0;
  logic [23:0] pkt_len = 0;
  logic [31:0] blk_addr = 0, chunk_addr = 0;
  logic [15:0] chunk_len = 0;
  logic        active, issue_valid, parked, done, acct_done, status_ready, err_out;
  logic [31:0] issue_addr;
  logic [43:0] issue_offset;
  logic [15:0] issue_len;
  logic [4:0]  sg_pages;

  dma_xfer_tracker u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  exp_t q[$];

  longint m_rem, m_idx, m_base;
  bit m_act, m_opt, m_nb, m_stat;
  int m_cmd;

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (issue_valid || done || parked)) begin
      if (q.size() == 0) chk("R11", "unexpected event", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, "issue_valid", issue_valid, e.iss);
        chk(e.req, "done", done, e.dn);
        chk(e.req, "parked", parked, e.prk);
        chk(e.req, "acct_done", acct_done, e.acct);
        chk(e.req, "status_ready", status_ready, e.stat);
        if (e.iss) begin
          chk(e.req, "issue_offset", issue_offset, e.ofs);
          chk(e.req, "issue_len", issue_len, e.len);
          chk("R10", "sg_pages", sg_pages, e.pgs);
          chk(e.req, "issue_addr", issue_addr, e.addr);
        end
      end
    end
  end

  task automatic begin_xfer(bit opt, bit nb, int c, int cnt, int pkt, int base);
    @(negedge clk);
    start = 1; is_optical = opt; nonblock = nb; cmd = 2'(c);
    sector_cnt = 16'(cnt); pkt_len = 24'(pkt); blk_addr = base;
    m_act = 1; m_opt = opt; m_nb = nb; m_cmd = c; m_idx = 0; m_base = base; m_stat = 0;
    m_rem = opt ? longint'(pkt) : longint'(cnt) * 512;
    @(negedge clk);
    start = 0;
    chk("R1", "active after start", active, 1);
    chk("R1", "err_out after start", err_out, 0);
    chk("R1", "status after start", status_ready, 0);
  endtask

  task automatic send_chunk(int len, string req);
    exp_t e;
    int unsigned a;
    a = 32'h1000_0000 + 32'(len) * 3;
    e = '{iss:0, dn:0, prk:0, acct:0, stat:m_stat, ofs:0, len:0, pgs:0, addr:a, req:req};
    if (!m_act) e.prk = 1;
    else if (m_rem <= 0) begin
      e.dn = 1; e.acct = (m_cmd < 2); m_act = 0;
      if (!m_opt) m_stat = 1;
      e.stat = m_stat;
    end else begin
      int l;
      l = (m_opt && m_nb && m_rem < len) ? int'(m_rem) : len;
      e.iss = 1; e.len = l; e.pgs = l / 4096 + 1;
      e.ofs = (m_opt ? (m_base << 11) : (m_base << 9)) + m_idx;
      m_idx += l; m_rem -= l;
      if (m_opt && m_nb) begin e.dn = 1; e.acct = (m_cmd < 2); m_act = 0; end
    end
    q.push_back(e);
    @(negedge clk);
    chunk_valid = 1; chunk_len = 16'(len); chunk_addr = a;
    @(negedge clk);
    chunk_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("R11", "watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_act = 0; m_stat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset active", active, 0);
    chk("R9", "reset err_out", err_out, 0);
    chk("R5", "reset status", status_ready, 0);
    chk("R11", "reset issue", issue_valid, 0);

    send_chunk(512, "R6");

    begin_xfer(0, 0, 0, 3, 0, 32'h123);
    send_chunk(1024, "R2");
    send_chunk(512, "R4");
    send_chunk(512, "R5");
    chk("R5", "active after disk done", active, 0);

    begin_xfer(1, 0, 0, 0, 6000, 5);
    send_chunk(4096, "R3");
    send_chunk(4096, "R4");
    send_chunk(4096, "R5");
    chk("R5", "optical leaves status", status_ready, 0);

    begin_xfer(1, 1, 0, 0, 100, 7);
    send_chunk(512, "R7");
    chk("R7", "nonblock clears active", active, 0);
    begin_xfer(1, 1, 0, 0, 3000, 2);
    send_chunk(1000, "R7");
    send_chunk(1000, "R6");

    begin_xfer(0, 0, 2, 1, 0, 9);
    send_chunk(512, "R8");
    send_chunk(512, "R8");
    begin_xfer(0, 0, 1, 1, 0, 9);
    send_chunk(512, "R8");
    send_chunk(512, "R8");

    begin_xfer(0, 0, 0, 40, 0, 4);
    send_chunk(8191, "R10");
    send_chunk(8192, "R10");
    @(negedge clk); err_in = 1;
    @(negedge clk); err_in = 0; m_act = 0;
    chk("R9", "err_out set", err_out, 1);
    chk("R9", "active cleared", active, 0);
    send_chunk(512, "R9");
    @(negedge clk); err_in = 1;
    @(negedge clk); err_in = 0;
    chk("R9", "err_out held", err_out, 1);
    begin_xfer(0, 0, 0, 2, 0, 1);
    chk("R9", "start clears err", err_out, 0);
    send_chunk(512, "R1");

    begin_xfer(0, 0, 0, 2, 0, 77);
    send_chunk(512, "R1");

    begin_xfer(0, 0, 0, 0, 0, 3);
    send_chunk(512, "R5");

    repeat (3) @(negedge clk);
    chk("R11", "scoreboard drained", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule